// File: doc/BRIEF.md
# Recirculating Dual-Source Serial Shift Register

This block is a long serial delay line made of one or more sections of 64 storage stages each, all on one common clock. On every clock edge where the shift enable is high, one bit enters the first stage of the first section. Every stored bit moves one stage further along. The last stage of each section feeds the first stage of the next section. The last stage of the final section is driven out both as a true copy and as its complement.

The bit that enters comes from one of two sources. In normal mode, a select line picks one of two external serial inputs. In loop mode, the final output is fed back to the input, so the stored pattern circulates without change. A one-cycle shift pulse reports each shift that has taken place.

With the enable low, nothing moves and the contents are held for as long as the enable stays low. A synchronous reset clears every stage.

Top module: `serial_loop_shifter`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears every stage to 0 and takes priority over shifting. After it, `tail_q` reads 0, `tail_qn` reads 1 and `shift_pulse` reads 0.
- R2: At a rising edge with `shift_en` high, the feed bit enters stage 0 of the first section. Every stored bit moves one stage toward the last stage of the final section.
- R3: In normal mode (`loop_mode` = 0), the feed bit is `in_a` when `src_sel` is 0 and `in_b` when `src_sel` is 1. Both the select and the data are sampled at the same edge.
- R4: `tail_qn` is always the logical complement of `tail_q`.
- R5: Each section has `STAGES` stages, and the last stage of each section feeds stage 0 of the next. A bit fed at enabled shift k appears on `tail_q` just after enabled shift k + STAGES*SECTIONS - 1. With the defaults, that is 127 shifts later.
- R6: In loop mode (`loop_mode` = 1), the feed bit is the current `tail_q`, and `in_a`, `in_b` and `src_sel` have no effect.
- R7: In loop mode, the contents return to their starting state after exactly STAGES*SECTIONS enabled shifts. As a result, the `tail_q` stream repeats with that period.
- R8: While `shift_en` is low, no stage changes, however many cycles pass.
- R9: `shift_pulse` is 1 for exactly the one clock cycle after each enabled shift edge, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst | input | 1 | Synchronous reset, active high |
| shift_en | input | 1 | Shift enable |
| in_a | input | 1 | Serial source A (chosen by `src_sel` = 0) |
| in_b | input | 1 | Serial source B (chosen by `src_sel` = 1) |
| src_sel | input | 1 | Source select for normal mode |
| loop_mode | input | 1 | 1 = recirculate the final output, 0 = take new data |
| tail_q | output | 1 | Last stage of the final section |
| tail_qn | output | 1 | Complement of `tail_q` |
| shift_pulse | output | 1 | High for one cycle after each shift |

## Verification
The assertions check the following on every cycle:
- reset clearing;
- the hold while the enable is low;
- the one-stage move inside each section;
- the feed bit's origin in both modes;
- the output complement;
- the shift pulse.

Only the bench's scenarios can show the end-to-end effects. These are the full latency across the chained sections, the repetition of the pattern after a whole loop, and correct behaviour when the select and the mode change in the middle of a stream. The bench shows them by comparing every shift against a queue model.

// File: rtl/sls_pkg.sv
package sls_pkg;
    typedef enum logic { SRC_A = 1'b0, SRC_B = 1'b1 } src_e;
    typedef enum logic { FEED_NEW = 1'b0, FEED_LOOP = 1'b1 } feed_e;
endpackage

// File: rtl/sls_feed_mux.sv
module sls_feed_mux
    import sls_pkg::*;
(
    input  logic in_a,
    input  logic in_b,
    input  logic src_sel,
    input  logic loop_mode,
    input  logic loop_bit,
    output logic feed
);
    src_e  src;
    feed_e fmode;
    logic  ext_bit;

    assign src   = src_e'(src_sel);
    assign fmode = feed_e'(loop_mode);

    always_comb begin
        unique case (src)
            SRC_A:   ext_bit = in_a;
            SRC_B:   ext_bit = in_b;
            default: ext_bit = in_a;
        endcase
    end

    always_comb begin
        unique case (fmode)
            FEED_NEW:  feed = ext_bit;
            FEED_LOOP: feed = loop_bit;
            default:   feed = ext_bit;
        endcase
    end
endmodule

// File: rtl/sls_section.sv
module sls_section #(
    parameter int STAGES = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst)
            stg <= '0;
        else if (en)
            stg <= {stg[STAGES-2:0], din};
    end

    assign dout = stg[STAGES-1];

    // R1
    clear_on_reset_chk: assert property (@(posedge clk) rst |=> stg == '0);
    // R8
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(stg));
    // R2
    entry_bit_chk: assert property (@(posedge clk) disable iff (rst)
        en |=> stg[0] == $past(din));
    // R2
    move_along_chk: assert property (@(posedge clk) disable iff (rst)
        en |=> stg[STAGES-1:1] == $past(stg[STAGES-2:0]));
endmodule

// File: rtl/serial_loop_shifter.sv
module serial_loop_shifter #(
    parameter int STAGES   = 64,
    parameter int SECTIONS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic shift_en,
    input  logic in_a,
    input  logic in_b,
    input  logic src_sel,
    input  logic loop_mode,
    output logic tail_q,
    output logic tail_qn,
    output logic shift_pulse
);
    localparam int TOTAL = STAGES * SECTIONS;

    logic [SECTIONS:0] link;
    logic              feed;

    sls_feed_mux u_mux (
        .in_a      (in_a),
        .in_b      (in_b),
        .src_sel   (src_sel),
        .loop_mode (loop_mode),
        .loop_bit  (link[SECTIONS]),
        .feed      (feed)
    );

    assign link[0] = feed;

    for (genvar g = 0; g < SECTIONS; g++) begin : g_sec
        sls_section #(.STAGES(STAGES)) u_sec (
            .clk  (clk),
            .rst  (rst),
            .en   (shift_en),
            .din  (link[g]),
            .dout (link[g+1])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)
            shift_pulse <= 1'b0;
        else
            shift_pulse <= shift_en;
    end

    assign tail_q  = link[SECTIONS];
    assign tail_qn = ~link[SECTIONS];

    // R4
    complement_chk: assert property (@(posedge clk) tail_qn == !tail_q);
    // R1
    reset_out_chk: assert property (@(posedge clk) rst |=> !tail_q && !shift_pulse);
    // R9
    pulse_chk: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> shift_pulse);
    // R9
    no_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> !shift_pulse);
    // R6
    loop_feed_chk: assert property (@(posedge clk) disable iff (rst)
        shift_en && loop_mode |=> g_sec[0].u_sec.stg[0] == $past(tail_q));
    // R3
    src_a_chk: assert property (@(posedge clk) disable iff (rst)
        shift_en && !loop_mode && !src_sel |=> g_sec[0].u_sec.stg[0] == $past(in_a));
    // R3
    src_b_chk: assert property (@(posedge clk) disable iff (rst)
        shift_en && !loop_mode && src_sel |=> g_sec[0].u_sec.stg[0] == $past(in_b));

    initial begin
        // R5
        depth_ok_chk: assert (TOTAL >= 2 && STAGES >= 2);
    end
endmodule

// File: tb/serial_loop_shifter_bench.sv
`timescale 1ns/1ps
module serial_loop_shifter_bench;
    localparam int STAGES = 64;
    localparam int SECTIONS = 2;
    localparam int TOT = STAGES * SECTIONS;

    logic clk = 1'b0;
    logic rst = 1'b1, shift_en = 1'b0, in_a = 1'b0, in_b = 1'b0;
    logic src_sel = 1'b0, loop_mode = 1'b0;
    logic tail_q, tail_qn, shift_pulse;

    int tests = 0, fails = 0;
    bit exp_q[$];
    logic trace[0:2*TOT-1];

    always #5 clk = ~clk;

    serial_loop_shifter #(.STAGES(STAGES), .SECTIONS(SECTIONS)) u_serial_loop_shifter (
        .clk(clk), .rst(rst), .shift_en(shift_en), .in_a(in_a), .in_b(in_b),
        .src_sel(src_sel), .loop_mode(loop_mode),
        .tail_q(tail_q), .tail_qn(tail_qn), .shift_pulse(shift_pulse)
    );

    task automatic check(input string req, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic model_clear();
        exp_q.delete();
        for (int i = 0; i < TOT; i++) exp_q.push_back(1'b0);
    endtask

    // driver: apply one cycle, push the expected bit into the queue
    task automatic step(input logic en, input logic sel, input logic mode,
                        input logic a, input logic b);
        bit d;
        shift_en = en; src_sel = sel; loop_mode = mode; in_a = a; in_b = b;
        @(posedge clk);
        if (en) begin
            d = mode ? exp_q[0] : (sel ? b : a);
            void'(exp_q.pop_front());
            exp_q.push_back(d);
        end
        @(negedge clk);
        // monitor: compare outputs with the queue head
        check(mode ? "R6" : (sel ? "R3" : "R2"), tail_q, exp_q[0]);
        check("R4", tail_qn, ~exp_q[0]);
        check("R9", shift_pulse, en);
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        model_clear();
        // R1 reset state
        check("R1", tail_q, 1'b0);
        check("R1", tail_qn, 1'b1);
        check("R1", shift_pulse, 1'b0);

        // R5 single marker: appears exactly TOT-1 shifts after entry
        step(1, 0, 0, 1, 0);
        for (int i = 1; i < TOT - 1; i++) begin
            step(1, 0, 0, 0, 1);
            if (tail_q !== 1'b0) check("R5 early", tail_q, 1'b0);
        end
        step(1, 0, 0, 0, 0);
        check("R5 marker", tail_q, 1'b1);

        // R2/R3 random data from A, then switch to B mid-stream
        for (int i = 0; i < 150; i++) step(1, 0, 0, 1'($urandom), 1'($urandom));
        for (int i = 0; i < 150; i++) step(1, 1, 0, 1'($urandom), 1'($urandom));
        for (int i = 0; i < 60; i++)  step(1, 1'($urandom), 0, 1'($urandom), 1'($urandom));

        // R8 idle: inputs wiggle, nothing moves
        for (int i = 0; i < 40; i++) begin
            logic prev;
            prev = tail_q;
            step(0, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
            check("R8", tail_q, prev);
        end
        // contents still intact after idle: replay the stored bits out
        for (int i = 0; i < 20; i++) step(1, 0, 0, 0, 0);

        // reload a fresh pattern, then R6/R7 loop
        for (int i = 0; i < TOT; i++) step(1, 1'($urandom), 0, 1'($urandom), 1'($urandom));
        for (int i = 0; i < 2 * TOT; i++) begin
            step(1, 1'($urandom), 1, 1'($urandom), 1'($urandom));
            trace[i] = tail_q;
        end
        for (int i = 0; i < TOT; i++) check("R7", trace[i + TOT], trace[i]);
        // loop with idle gaps in between
        for (int i = 0; i < 60; i++) step(1'($urandom), 0, 1, 1'($urandom), 1'($urandom));

        // mode switched back to new data mid-stream
        for (int i = 0; i < 80; i++) step(1, 0, 0, 1'($urandom), 1'($urandom));

        // R1 reset mid-stream beats enable
        rst = 1'b1; shift_en = 1'b1; in_a = 1'b1;
        @(negedge clk);
        rst = 1'b0; shift_en = 1'b0;
        model_clear();
        check("R1 mid", tail_q, 1'b0);
        check("R1 mid", tail_qn, 1'b1);
        check("R1 mid", shift_pulse, 1'b0);
        for (int i = 0; i < TOT; i++) step(1, 0, 1, 1, 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule